// File: doc/BRIEF.md
# Filtered Input Port with Change-of-State Flags

This block samples an eight-bit group of external input pins and presents them to a processor through two byte-wide read views on a simple register read port. The first view is a live snapshot of the general-purpose inputs. Inputs 0 to 3 and input 6 appear at their own bit positions, and the remaining bits read as zero. Nothing in this view is latched. It shows whatever level the synchronizer delivers at the moment of the read.

Inputs 0 to 3 are also monitored for changes of state. Each monitored input has a filter that accepts a new level only after the raw pin has held it for longer than a qualification window. By default that window is 50 microseconds at the configured clock rate. An accepted rising or falling transition sets a sticky flag. The second read view is a status byte. Its low nibble repeats the monitored inputs and its high nibble holds the four flags. A read of the status byte clears the flags once the read completes. An event that lands on the clearing cycle is kept. An `any_flag` output is high while any flag is set.

Each monitored channel has a filter state machine with three states. LOAD waits for startup; the transition LOAD→STABLE is taken when `go` rises, and it copies the synchronized level. In STABLE, the transition STABLE→PENDING is taken when the synchronized input differs from the accepted level. In PENDING, the transition PENDING→STABLE (reject) is taken when the input returns to the accepted level. The transition PENDING→STABLE (accept) is taken when the qualification count is reached; it updates the level and raises the change event. A startup sequencer has two states. FILL counts the synchronizer depth after reset, and the transition FILL→RUN is taken when that count completes. RUN drives `go` high.

Top module: `chgport_top`

## Requirements
- R1: A read with `rd_sel`=0 returns, on `rd_data` one cycle later, the synchronized levels of inputs 0, 1, 2, 3 and 6 at those same bit positions, with bits 4, 5 and 7 reading 0. The view is unlatched, so it follows the pins with a two-cycle synchronizer delay.
- R2: A read with `rd_sel`=1 returns, in `rd_data[3:0]`, the same four values that bits 3..0 of the input view would return in that cycle.
- R3: `rd_data[7:4]` of the status view are the change flags of inputs 3..0, with bit 4+i belonging to input i. A flag is set by an accepted rising transition and also by an accepted falling transition.
- R4: A transition is accepted only when the raw pin holds its new level for QUAL_CYC+1 consecutive clock samples or more, where QUAL_CYC = (CLK_HZ/1e6)*QUAL_US. A pulse of QUAL_CYC samples or fewer sets no flag.
- R5: A status read reports the flags as they stood before the read. All flags are 0 from the clock edge that completes the read onward.
- R6: When a transition is accepted on the same edge that completes a status read, the flag for that input is set after the read. The read itself returns the old value.
- R7: After reset, `rd_data` is 0 and all flags are 0. Each filter's accepted level is loaded from the synchronized pin, so pins that are held steady through reset never produce a flag.
- R8: `any_flag` is 1 exactly when at least one of status bits 7..4 is set.
- R9: If the raw pin first shows its new level at clock edge E0 and keeps it, the flag becomes visible right after edge E0+QUAL_CYC+2 and not before.
- R10: A read of the input view leaves the change flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_raw | input | 8 | Asynchronous external input pins |
| rd_en | input | 1 | Read strobe; one cycle per read |
| rd_sel | input | 1 | 0 selects the input view, 1 selects the status view |
| rd_data | output | 8 | Read result, registered and valid the cycle after `rd_en` |
| any_flag | output | 1 | High while any change flag is set |

## Verification
A pin change that is driven just before edge E0 reaches the synchronized view after edge E1. A read strobed on the following cycle therefore captures it at E2, and `rd_data` is sampled one cycle after the strobe. A held change raises its flag right after edge E0+QUAL_CYC+2. The bench drives and samples only on falling edges and counts the exact number of falling edges from the stimulus. It checks that `any_flag` is still low one cycle before the due point and high at it. For the same-cycle case, the status read is timed so that it completes on the acceptance edge, and the bench expects the old value on `rd_data` while the flag survives the clear.

// File: rtl/chgport_pkg.sv
package chgport_pkg;
    localparam int PORT_W = 8;
    localparam int MON_W  = 4;

    typedef enum logic [1:0] {
        F_LOAD,
        F_STABLE,
        F_PEND
    } filt_state_t;

    typedef enum logic {
        B_FILL,
        B_RUN
    } boot_state_t;

    localparam logic SEL_INPUT  = 1'b0;
    localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/chgport_sync.sv
module chgport_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/chgport_boot.sv
module chgport_boot
    import chgport_pkg::*;
#(
    parameter int FILL = 2
) (
    input  logic clk,
    input  logic rst,
    output logic go
);
    localparam int CW = (FILL < 2) ? 1 : $clog2(FILL);

    boot_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(FILL - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            B_FILL:  if (last) state_d = B_RUN;
            B_RUN:   state_d = B_RUN;
            default: state_d = B_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= B_FILL;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst)                               cnt_q <= '0;
        else if (state_q == B_FILL && !last)   cnt_q <= cnt_q + 1'b1;
    end

    assign go = (state_q == B_RUN);

    // R7
    go_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> go);
endmodule

// File: rtl/chgport_filter.sv
module chgport_filter
    import chgport_pkg::*;
#(
    parameter int QUAL_CYC = 2500
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic sync_in,
    output logic lvl_o,
    output logic chg_o
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_CYC);

    filt_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          lvl_q;
    logic          differs;
    logic          done;

    assign differs = (sync_in != lvl_q);
    assign done    = (cnt_q == CNT_MAX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            F_LOAD:   if (go) state_d = F_STABLE;
            F_STABLE: if (differs) state_d = F_PEND;
            F_PEND:   if (!differs || done) state_d = F_STABLE;
            default:  state_d = F_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= F_LOAD;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            unique case (state_q)
                F_LOAD: begin
                    cnt_q <= '0;
                    if (go) lvl_q <= sync_in;
                end
                F_STABLE: begin
                    cnt_q <= differs ? CW'(1) : '0;
                end
                F_PEND: begin
                    if (!differs) begin
                        cnt_q <= '0;
                    end else if (done) begin
                        cnt_q <= '0;
                        lvl_q <= sync_in;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    assign lvl_o = lvl_q;
    assign chg_o = (state_q == F_PEND) && differs && done;

    // R4
    lvl_needs_full_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lvl_q) && $past(state_q) != F_LOAD) |-> $past(cnt_q) == CNT_MAX);

    // R4
    glitch_resets_count_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == F_PEND && $past(sync_in) == $past(lvl_q))
            |-> (cnt_q == '0 && $stable(lvl_q)));

    // R3
    chg_moves_level_chk: assert property (@(posedge clk) disable iff (rst)
        chg_o |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/chgport_top.sv
module chgport_top
    import chgport_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int QUAL_US     = 50,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] IN_MASK = 8'h4F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_raw,
    input  logic       rd_en,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    output logic       any_flag
);
    localparam int QUAL_CYC = (CLK_HZ / 1_000_000) * QUAL_US;

    logic [PORT_W-1:0] sync_v;
    logic              go;
    logic [MON_W-1:0]  lvl_v;
    logic [MON_W-1:0]  evt_v;
    logic [MON_W-1:0]  flags_q;
    logic [PORT_W-1:0] rd_q;
    logic [PORT_W-1:0] in_view;
    logic [PORT_W-1:0] stat_view;
    logic              rd_clr;

    chgport_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (in_raw),
        .q   (sync_v)
    );

    chgport_boot #(.FILL(SYNC_STAGES)) u_boot (
        .clk (clk),
        .rst (rst),
        .go  (go)
    );

    for (genvar i = 0; i < MON_W; i++) begin : g_mon
        chgport_filter #(.QUAL_CYC(QUAL_CYC)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .go      (go),
            .sync_in (sync_v[i]),
            .lvl_o   (lvl_v[i]),
            .chg_o   (evt_v[i])
        );
    end

    assign in_view   = sync_v & IN_MASK;
    assign stat_view = {flags_q, sync_v[MON_W-1:0]};
    assign rd_clr    = rd_en && (rd_sel == SEL_STATUS);

    always_ff @(posedge clk) begin
        if (rst)         flags_q <= '0;
        else if (rd_clr) flags_q <= evt_v;
        else             flags_q <= flags_q | evt_v;
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= (rd_sel == SEL_STATUS) ? stat_view : in_view;
    end

    assign rd_data  = rd_q;
    assign any_flag = |flags_q;

    // R6
    evt_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
        |evt_v |=> ((flags_q & $past(evt_v)) == $past(evt_v)));

    // R5
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> ((flags_q & ~$past(evt_v)) == '0));

    // R3
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        ((flags_q & ~$past(flags_q)) != '0) |-> ((flags_q & ~$past(flags_q) & ~$past(evt_v)) == '0));

    // R10
    in_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_INPUT) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R1
    in_view_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_INPUT) |=> (rd_data & ~IN_MASK) == '0);
endmodule

// File: tb/chgport_top_tb.sv
module chgport_top_tb;
    localparam int CLK_HZ  = 50_000_000;
    localparam int QUAL_US = 1;
    localparam int Q       = (CLK_HZ / 1_000_000) * QUAL_US;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] in_raw;
    logic       rd_en;
    logic       rd_sel;
    logic [7:0] rd_data;
    logic       any_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    chgport_top #(.CLK_HZ(CLK_HZ), .QUAL_US(QUAL_US)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .in_raw   (in_raw),
        .rd_en    (rd_en),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .any_flag (any_flag)
    );

    always #10 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        rd_en  = 1'b1;
        rd_sel = sel;
        tick(1);
        rd_en  = 1'b0;
        d      = rd_data;
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] cur;
        rst = 1'b1; in_raw = 8'hE5; rd_en = 1'b0; rd_sel = 1'b0;
        tick(5);
        rst = 1'b0;
        chk("R7 rd_data after reset", rd_data, 8'h00);
        chk("R7 any_flag after reset", {7'b0, any_flag}, 8'h00);
        tick(Q + 10);
        chk("R7 no false change", {7'b0, any_flag}, 8'h00);
        rd(1'b1, d);
        chk("R7 R2 status after reset", d, 8'h05);
        rd(1'b0, d);
        chk("R1 input view after reset", d, 8'h45);

        // R1 R2 R4: sweep every pin value; runs stay shorter than Q
        for (int v = 0; v < 256; v++) begin
            in_raw = 8'(v);
            tick(2);
            rd(1'b0, d);
            chk("R1 input view sweep", d, 8'(v) & 8'h4F);
            rd(1'b1, d);
            chk("R2 status low nibble sweep", d, {4'h0, 4'(v)});
        end
        in_raw = 8'hE5;
        tick(Q + 10);
        chk("R4 short runs ignored", {7'b0, any_flag}, 8'h00);

        for (int i = 0; i < 4; i++) begin
            cur = in_raw;
            // R4 pulse of exactly Q samples is rejected
            in_raw = cur ^ (8'h1 << i);
            tick(Q);
            in_raw = cur;
            tick(Q + 10);
            chk("R4 Q-cycle pulse rejected", {7'b0, any_flag}, 8'h00);
            rd(1'b1, d);
            chk("R4 no flag after Q pulse", d, {4'h0, cur[3:0]});
            // R9 held change: exact due cycle
            in_raw = cur ^ (8'h1 << i);
            tick(Q + 2);
            chk("R9 flag not early", {7'b0, any_flag}, 8'h00);
            tick(1);
            chk("R9 flag on time", {7'b0, any_flag}, 8'h01);
            rd(1'b0, d);
            chk("R10 input read", d, in_raw & 8'h4F);
            chk("R10 flag kept", {7'b0, any_flag}, 8'h01);
            rd(1'b1, d);
            chk("R3 flag position", d, {4'h1 << i, in_raw[3:0]});
            chk("R5 cleared any_flag", {7'b0, any_flag}, 8'h00);
            rd(1'b1, d);
            chk("R5 flags cleared", d, {4'h0, in_raw[3:0]});
            // R3 opposite direction
            in_raw = cur;
            tick(Q + 10);
            rd(1'b1, d);
            chk("R3 reverse direction", d, {4'h1 << i, in_raw[3:0]});
        end

        // R6 event accepted on the clearing read edge
        cur = in_raw;
        in_raw = cur ^ 8'h01;
        tick(Q + 2);
        rd(1'b1, d);
        chk("R6 read shows old flags", d, {4'h0, in_raw[3:0]});
        chk("R6 flag survives clear", {7'b0, any_flag}, 8'h01);
        rd(1'b1, d);
        chk("R6 flag reported", d, {4'h1, in_raw[3:0]});

        // R8 all four at once
        in_raw = in_raw ^ 8'h0F;
        tick(Q + 10);
        chk("R8 any_flag set", {7'b0, any_flag}, 8'h01);
        rd(1'b1, d);
        chk("R8 R3 all flags", d, {4'hF, in_raw[3:0]});
        chk("R8 any_flag clear", {7'b0, any_flag}, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule